// File: doc/BRIEF.md
# Multi-Bank Scratchpad Crossbar Datapath

This block holds the banks of a lane-parallel scratchpad and carries requests from the lanes to them. In each cycle it takes a group of lane requests that an upstream serializer has already made free of bank conflicts. Each lane supplies an address, write data, a byte mask and a served bit. One store flag applies to every lane. The address of each lane splits into a bank number and a row within that bank. For every bank, a steering unit picks the lowest-numbered served lane that targets the bank and drives that bank's single port.

Read data comes back one cycle after the access and is routed to every served lane that named that bank. If several lanes read the same word, they all get the result of one access. A collector stores the lane results from each serialized sub-request. When the sub-request marked last has been handled, the collector presents the whole vector for one cycle. Lanes that were never served read as zero. Store instructions return an all-zero vector.

Top module: `spm_xbar`

## Requirements
- R1: With B banks, W bytes per word and D rows per bank, address bits [log2(W) +: log2(B)] select the bank. The top log2(D) address bits select the row inside that bank. The low log2(W) bits are ignored.
- R2: When a store is served, mask bit k writes byte k of the word (data bits 8k+7..8k). Bytes whose mask bit is 0 keep their old value.
- R3: When several served lanes target one bank, the lowest-numbered of them drives the bank. A later read of that word returns the value that lane wrote.
- R4: On a read, every served lane whose address points at the same word receives that word.
- R5: A bank that no served lane targets does nothing. A store from a lane whose served bit is 0 leaves memory unchanged.
- R6: An instruction's result appears on `res_valid`/`res_data` exactly two rising edges after the edge that captures its last sub-request. Instructions issued in consecutive cycles produce results in consecutive cycles.
- R7: A sub-request with `req_last` = 0 produces no output. `res_valid` is high for exactly one cycle per instruction.
- R8: In a read result, a lane that was served in no sub-request of the instruction reads zero. A store instruction returns an all-zero vector.
- R9: The collector clears at the first sub-request of every instruction. No lane value from an earlier instruction shows up in a later result.
- R10: While reset is high and after it is released, `res_valid` is 0 and `res_data` is 0 until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A sub-request is present this cycle |
| req_last | input | 1 | This sub-request is the last of its instruction |
| is_store | input | 1 | 1 = write, 0 = read, shared by all lanes |
| lane_addr | input | LANES*AW | Per-lane byte address, lane l at [l*AW +: AW] |
| lane_wdata | input | LANES*8*BYTES | Per-lane write word |
| lane_bmask | input | LANES*BYTES | Per-lane byte write mask |
| lane_sat | input | LANES | Per-lane served bit for this sub-request |
| res_valid | output | 1 | Result vector valid, one cycle per instruction |
| res_data | output | LANES*8*BYTES | Collected per-lane read data |

## Verification
A sub-request is captured at one rising edge, and the bank read and routing registers take one more edge to produce their values. The collector and the valid flag are therefore updated at the second edge after capture. The bench drives inputs on falling edges. It checks that nothing is valid at the falling edge after capture, and it samples the result at the falling edge after the second rising edge. For two-part instructions and back-to-back instructions, the bench advances exactly one cycle per sub-request, so it knows which falling edge must show the pulse and which must not.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int DEF_LANES = 16;
    localparam int DEF_BANKS = 16;
    localparam int DEF_DEPTH = 1024;
    localparam int DEF_BYTES = 4;

    // control travelling alongside the bank access
    typedef struct packed {
        logic vld;
        logic last;
        logic first;
        logic store;
    } sub_ctl_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/spm_bank.sv
module spm_bank #(
    parameter int DEPTH = 1024,
    parameter int BYTES = 4,
    localparam int OB = $clog2(DEPTH),
    localparam int DW = 8 * BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             we,
    input  logic [OB-1:0]    off,
    input  logic [BYTES-1:0] bmask,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int k = 0; k < BYTES; k++) begin
                if (bmask[k]) mem[off][8*k +: 8] <= wdata[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (en && !we)
            rdata <= mem[off];
    end

    // R2
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && we) |=> $stable(rdata));

endmodule

// File: rtl/spm_steer.sv
module spm_steer #(
    parameter int LANES   = 16,
    parameter int BB      = 4,
    parameter int BANK_ID = 0,
    localparam int LW = spm_pkg::idx_bits(LANES)
) (
    input  logic [LANES*BB-1:0] lane_bank,
    input  logic [LANES-1:0]    sat,
    output logic                en,
    output logic [LW-1:0]       sel
);

    logic [LANES-1:0] hit;
    logic             found;

    for (genvar l = 0; l < LANES; l++) begin : g_cmp
        assign hit[l] = sat[l] && (lane_bank[l*BB +: BB] == BB'(BANK_ID));
    end

    // lane 0 has top priority: scan downward so the lowest hit wins
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel   = LW'(i);
                found = 1'b1;
            end
        end
    end

    assign en = found && sat[sel];

endmodule

// File: rtl/spm_collect.sv
module spm_collect #(
    parameter int LANES = 16,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  spm_pkg::sub_ctl_t      ctl,
    input  logic [LANES-1:0]       sat,
    input  logic [LANES*DW-1:0]    lane_rd,
    output logic                   res_valid,
    output logic [LANES*DW-1:0]    res_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= ctl.vld && ctl.last;
            if (ctl.vld) begin
                for (int l = 0; l < LANES; l++) begin
                    if (sat[l] && !ctl.store)
                        res_data[l*DW +: DW] <= lane_rd[l*DW +: DW];
                    else if (ctl.first)
                        res_data[l*DW +: DW] <= '0;
                end
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R9
        clr_chk: assert property (@(posedge clk) disable iff (rst)
            (ctl.vld && ctl.first && !(sat[l] && !ctl.store))
                |=> (res_data[l*DW +: DW] == '0));
    end

endmodule

// File: rtl/spm_xbar.sv
module spm_xbar
    import spm_pkg::*;
#(
    parameter int LANES = DEF_LANES,
    parameter int BANKS = DEF_BANKS,
    parameter int DEPTH = DEF_DEPTH,
    parameter int BYTES = DEF_BYTES,
    localparam int DW  = 8 * BYTES,
    localparam int BYB = $clog2(BYTES),
    localparam int BB  = $clog2(BANKS),
    localparam int OB  = $clog2(DEPTH),
    localparam int AW  = OB + BB + BYB,
    localparam int LW  = idx_bits(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_last,
    input  logic                   is_store,
    input  logic [LANES*AW-1:0]    lane_addr,
    input  logic [LANES*DW-1:0]    lane_wdata,
    input  logic [LANES*BYTES-1:0] lane_bmask,
    input  logic [LANES-1:0]       lane_sat,
    output logic                   res_valid,
    output logic [LANES*DW-1:0]    res_data
);

    logic [BB-1:0]      bank_a [LANES];
    logic [OB-1:0]      off_a  [LANES];
    logic [DW-1:0]      wd_a   [LANES];
    logic [BYTES-1:0]   bm_a   [LANES];
    logic [LANES*BB-1:0] bank_flat;
    logic [LANES-1:0]   sat_g;
    logic [DW-1:0]      bank_rd [BANKS];

    assign sat_g = lane_sat & {LANES{req_valid}};

    // cyclic address split per lane
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [AW-1:0] a;
        assign a        = lane_addr[l*AW +: AW];
        assign bank_a[l] = a[BYB +: BB];
        assign off_a[l]  = a[AW-1 -: OB];
        assign wd_a[l]   = lane_wdata[l*DW +: DW];
        assign bm_a[l]   = lane_bmask[l*BYTES +: BYTES];
        assign bank_flat[l*BB +: BB] = bank_a[l];
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic          en_b;
        logic [LW-1:0] sel_b;
        logic          lower_hit;

        spm_steer #(.LANES(LANES), .BB(BB), .BANK_ID(b)) u_steer (
            .lane_bank (bank_flat),
            .sat       (sat_g),
            .en        (en_b),
            .sel       (sel_b)
        );

        spm_bank #(.DEPTH(DEPTH), .BYTES(BYTES)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .en    (en_b),
            .we    (is_store),
            .off   (off_a[sel_b]),
            .bmask (bm_a[sel_b]),
            .wdata (wd_a[sel_b]),
            .rdata (bank_rd[b])
        );

        always_comb begin
            lower_hit = 1'b0;
            for (int j = 0; j < LANES; j++) begin
                if (j < int'(sel_b) && sat_g[j] && bank_a[j] == BB'(b))
                    lower_hit = 1'b1;
            end
        end

        // R3
        prio_chk: assert property (@(posedge clk) disable iff (rst)
            en_b |-> (!lower_hit && sat_g[sel_b] && bank_a[sel_b] == BB'(b)));
    end

    // registers aligned with the one-cycle bank read
    sub_ctl_t         ctl_q;
    logic [LANES-1:0] sat_q;
    logic [BB-1:0]    bank_q [LANES];
    logic             first_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            sat_q      <= '0;
            first_pend <= 1'b1;
            for (int l = 0; l < LANES; l++) bank_q[l] <= '0;
        end else begin
            ctl_q <= '{vld: req_valid, last: req_last, first: first_pend, store: is_store};
            sat_q <= sat_g;
            if (req_valid) first_pend <= req_last;
            for (int l = 0; l < LANES; l++) bank_q[l] <= bank_a[l];
        end
    end

    logic [LANES*DW-1:0] lane_rd;
    for (genvar l = 0; l < LANES; l++) begin : g_route
        assign lane_rd[l*DW +: DW] = bank_rd[bank_q[l]];
    end

    spm_collect #(.LANES(LANES), .DW(DW)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_q),
        .sat       (sat_q),
        .lane_rd   (lane_rd),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    // R6
    lat_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(req_valid, 2) && $past(req_last, 2)));

    // R7
    no_early_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid, 2) && !$past(req_last, 2)) |-> !res_valid);

endmodule

// File: tb/tb_spm_xbar.sv
`timescale 1ns/1ps
module tb_spm_xbar;

    localparam int L = 4, B = 4, D = 8, W = 2;
    localparam int DW = 16, AW = 6, WORDS = B * D;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid, req_last, is_store;
    logic [L*AW-1:0] lane_addr;
    logic [L*DW-1:0] lane_wdata;
    logic [L*W-1:0]  lane_bmask;
    logic [L-1:0]    lane_sat;
    logic            res_valid;
    logic [L*DW-1:0] res_data;

    int n_run = 0, n_fail = 0;
    logic [15:0] model [WORDS];
    logic [15:0] expv [L];
    int lane_word [L];

    always #4 clk = ~clk;

    spm_xbar #(.LANES(L), .BANKS(B), .DEPTH(D), .BYTES(W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_last(req_last),
        .is_store(is_store), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
        .lane_bmask(lane_bmask), .lane_sat(lane_sat),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_last = 0; is_store = 0; lane_sat = '0;
    endtask

    // byte address of word w: bank = w % B, row = w / B (R1)
    task automatic put(int l, int w, logic [15:0] d, logic [1:0] m, bit s);
        lane_addr[l*AW +: AW] = AW'(w * W) | AW'(s ? 0 : 1);
        lane_addr[l*AW +: AW] = AW'(w * W) + AW'((l & 1));  // low byte bit ignored
        lane_wdata[l*DW +: DW] = d;
        lane_bmask[l*W +: W]  = m;
        lane_sat[l]           = s;
        lane_word[l]          = w;
    endtask

    // store model: per bank only the lowest served lane writes
    task automatic commit_store();
        for (int b = 0; b < B; b++) begin
            for (int l = 0; l < L; l++) begin
                if (lane_sat[l] && (lane_word[l] % B) == b) begin
                    for (int k = 0; k < W; k++)
                        if (lane_bmask[l*W + k])
                            model[lane_word[l]][8*k +: 8] = lane_wdata[l*DW + 8*k +: 8];
                    break;
                end
            end
        end
    endtask

    task automatic set_read_exp();
        for (int l = 0; l < L; l++) expv[l] = lane_sat[l] ? model[lane_word[l]] : 16'h0;
    endtask

    // one sub-request already driven; wait to result sample point
    task automatic step(input string req);
        @(negedge clk);
        chk({req, " not early"}, {31'd0, res_valid}, 32'd0);
        idle();
        @(negedge clk);
    endtask

    task automatic chk_lanes(input string req);
        chk({req, " valid"}, {31'd0, res_valid}, 32'd1);
        for (int l = 0; l < L; l++) chk(req, {16'd0, res_data[l*DW +: DW]}, {16'd0, expv[l]});
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(); lane_addr = '0; lane_wdata = '0; lane_bmask = '0;
        for (int l = 0; l < L; l++) lane_word[l] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 valid in reset", {31'd0, res_valid}, 32'd0);
        rst = 0;
        @(negedge clk);
        chk("R10 valid", {31'd0, res_valid}, 32'd0);
        chk("R10 data", res_data[31:0], 32'd0);

        // fill every word, one bank per lane
        for (int k = 0; k < D; k++) begin
            is_store = 1; req_valid = 1; req_last = 1;
            for (int l = 0; l < L; l++)
                put(l, 4*k + l, 16'((4*k + l) * 16'h1357) ^ 16'h0A5C, 2'b11, 1);
            commit_store();
            step("R6 store");
            chk("R8 store valid", {31'd0, res_valid}, 32'd1);
            chk("R8 store zero", res_data[31:0], 32'd0);
            chk("R8 store zero hi", res_data[63:32], 32'd0);
        end

        // read sweep with rotated lane-to-bank mapping
        for (int k = 0; k < D; k++) begin
            req_valid = 1; req_last = 1;
            for (int l = 0; l < L; l++) put(l, 4*k + ((l + k) % 4), 16'h0, 2'b00, 1);
            set_read_exp();
            step("R6 read");
            chk_lanes("R1 R3 read");
        end

        // byte masks, unserved lane and empty mask
        is_store = 1; req_valid = 1; req_last = 1;
        put(0, 5, 16'hAAAA, 2'b01, 1);
        put(1, 6, 16'h5555, 2'b10, 1);
        put(2, 7, 16'hFFFF, 2'b11, 0);
        put(3, 12, 16'hFFFF, 2'b00, 1);
        commit_store();
        step("R2 store");
        req_valid = 1; req_last = 1;
        put(0, 5, 0, 0, 1); put(1, 6, 0, 0, 1); put(2, 7, 0, 0, 1); put(3, 12, 0, 0, 1);
        set_read_exp();
        step("R2 read");
        chk_lanes("R2 R5 mask");

        // two lanes storing to one word: lane 0 wins
        is_store = 1; req_valid = 1; req_last = 1;
        put(0, 9, 16'h1111, 2'b11, 1);
        put(1, 9, 16'h3333, 2'b11, 0);
        put(2, 9, 16'h2222, 2'b11, 1);
        put(3, 9, 16'h4444, 2'b11, 0);
        commit_store();
        step("R3 store");
        req_valid = 1; req_last = 1;
        for (int l = 0; l < L; l++) put(l, 9, 0, 0, 1);
        set_read_exp();
        step("R4 read");
        chk_lanes("R3 R4 broadcast");
        chk("R3 winner", {16'd0, res_data[15:0]}, 32'h1111);

        // two-part instruction
        req_valid = 1; req_last = 0;
        put(0, 1, 0, 0, 1); put(1, 2, 0, 0, 1); put(2, 3, 0, 0, 0); put(3, 4, 0, 0, 0);
        expv[0] = model[1]; expv[1] = model[2];
        @(negedge clk);
        chk("R7 none", {31'd0, res_valid}, 32'd0);
        req_last = 1;
        put(0, 1, 0, 0, 0); put(1, 2, 0, 0, 0); put(2, 3, 0, 0, 1); put(3, 4, 0, 0, 0);
        expv[2] = model[3]; expv[3] = 16'h0;
        @(negedge clk);
        chk("R7 no output on non-last", {31'd0, res_valid}, 32'd0);
        idle();
        @(negedge clk);
        chk_lanes("R7 R8 collect");
        @(negedge clk);
        chk("R7 one pulse", {31'd0, res_valid}, 32'd0);

        // new instruction clears earlier lanes
        req_valid = 1; req_last = 1;
        put(0, 1, 0, 0, 0); put(1, 2, 0, 0, 0); put(2, 3, 0, 0, 0); put(3, 13, 0, 0, 1);
        set_read_exp();
        step("R9 read");
        chk_lanes("R9 clear");

        // back-to-back single-cycle instructions
        req_valid = 1; req_last = 1;
        for (int l = 0; l < L; l++) put(l, l, 0, 0, 1);
        set_read_exp();
        @(negedge clk);
        for (int l = 0; l < L; l++) put(l, 4 + l, 0, 0, 1);
        @(negedge clk);
        idle();
        chk_lanes("R6 b2b first");
        for (int l = 0; l < L; l++) expv[l] = model[4 + l];
        @(negedge clk);
        chk_lanes("R6 b2b second");
        @(negedge clk);
        chk("R7 b2b end", {31'd0, res_valid}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule